// File: doc/BRIEF.md
# Booth Multiply-Accumulate Unit

This block is a signed multiply-accumulate datapath for a signal-processing core. It multiplies two 17-bit two's-complement operands and folds the 34-bit product into a 40-bit guarded accumulator, all within one clock cycle. The multiplier recodes one operand with radix-4 Booth digits, which gives nine partial products. These are summed in a single combinational tree.

Each accepted command does one of five things. It can load the product, add the product to the accumulator, subtract the product from it, load the square of one operand, or add that square to the accumulator. The first operand can come from the 17-bit field in bits 31..15 of an external 40-bit accumulator value instead of the direct operand port. This lets a running result feed back into the multiplier. Accumulation wraps modulo 2^40, and a flag reports a signed wrap on the most recent accumulating command.

Top module: `booth_mac`

## Requirements
- R1: After `rst_ni` is deasserted, `result_o` is 0 and `ovf_o` is 0.
- R2: Op code 0 (product load) sets `result_o` to the 40-bit sign-extended product of the two 17-bit signed operands on the clock edge that accepts the command.
- R3: Op code 1 (accumulate) sets `result_o` to the previous `result_o` plus the sign-extended product, modulo 2^40.
- R4: Op code 2 (deduct) sets `result_o` to the previous `result_o` minus the sign-extended product, modulo 2^40.
- R5: Op code 3 loads the square of the first operand, and op code 4 adds that square to the previous `result_o`. For both codes, `b_i` is ignored.
- R6: When `acc_sel_i` is 1, the first operand is `ext_acc_i[31:15]` and `a_i` is ignored. Square codes then square that field.
- R7: `ovf_o` is set by op codes 1, 2 or 4 exactly when the 40-bit signed sum wraps. Otherwise those codes clear it. Op codes 0 and 3 clear it.
- R8: When `valid_i` is 0, or when the op code is 5, 6 or 7, both `result_o` and `ovf_o` keep their values.
- R9: Commands on consecutive cycles are each applied in turn, with no idle cycle between them.
- R10: The most negative operands (-65536 x -65536) produce exactly +2^32, and 128 such accumulations starting from 0 wrap the accumulator to -2^39 with `ovf_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Command accepted on this edge |
| op_i | input | 3 | Op code: 0 load, 1 add, 2 deduct, 3 square, 4 square-add |
| a_i | input | 17 | First signed operand (multiplicand) |
| b_i | input | 17 | Second signed operand (Booth-recoded) |
| acc_sel_i | input | 1 | Take first operand from `ext_acc_i[31:15]` |
| ext_acc_i | input | 40 | External accumulator value |
| result_o | output | 40 | Accumulator contents |
| ovf_o | output | 1 | Signed wrap on last accumulating command |

## Verification
Random operands across the full 17-bit range mix all five op codes. This separates a correct Booth digit table from one with a wrong sign or a wrong doubling, because each recoding group value turns up many times. Directed extremes (0, +-1, +65535, -65536) exercise the top digit, which is decoded from sign-extension bits. A run of 128 most-negative squares, followed by a deduct, forces wraps in both directions and checks the overflow flag against plain accumulations. Idle cycles, reserved codes and a changing `ext_acc_i` under `acc_sel_i` show which inputs are allowed to matter and which are not.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;
  typedef enum logic [2:0] {
    OP_MPY  = 3'd0,
    OP_MAC  = 3'd1,
    OP_MAS  = 3'd2,
    OP_SQR  = 3'd3,
    OP_SQRA = 3'd4
  } mac_op_e;
endpackage

// File: rtl/booth_pp_gen.sv
module booth_pp_gen #(
  parameter int OP_W  = 17,
  parameter int ACC_W = 40,
  localparam int NPP  = (OP_W + 1) / 2
) (
  input  logic [OP_W-1:0]            mcand_i,
  input  logic [OP_W-1:0]            mplier_i,
  output logic [NPP-1:0][ACC_W-1:0]  pp_o
);
  localparam int MX_W = 2 * NPP + 1;

  logic [MX_W-1:0]  mx;
  logic [ACC_W-1:0] mcand_ext;

  // implied zero below lsb, sign fill above msb
  assign mx        = {{(MX_W - OP_W - 1){mplier_i[OP_W-1]}}, mplier_i, 1'b0};
  assign mcand_ext = {{(ACC_W - OP_W){mcand_i[OP_W-1]}}, mcand_i};

  for (genvar j = 0; j < NPP; j++) begin : g_pp
    logic [2:0]       grp;
    logic             neg, one, two;
    logic [ACC_W-1:0] mag, sgn;

    assign grp = mx[2*j+2 -: 3];

    always_comb begin
      neg = 1'b0;
      one = 1'b0;
      two = 1'b0;
      unique case (grp)
        3'b001, 3'b010: one = 1'b1;
        3'b011:         two = 1'b1;
        3'b100:         begin two = 1'b1; neg = 1'b1; end
        3'b101, 3'b110: begin one = 1'b1; neg = 1'b1; end
        default:        ;
      endcase
    end

    assign mag     = two ? (mcand_ext << 1) : (one ? mcand_ext : '0);
    assign sgn     = neg ? (~mag + 1'b1) : mag;
    assign pp_o[j] = sgn << (2 * j);
  end
endmodule

// File: rtl/booth_pp_sum.sv
module booth_pp_sum #(
  parameter int NPP   = 9,
  parameter int ACC_W = 40
) (
  input  logic [NPP-1:0][ACC_W-1:0] pp_i,
  output logic [ACC_W-1:0]          prod_o
);
  always_comb begin
    prod_o = '0;
    for (int k = 0; k < NPP; k++) prod_o = prod_o + pp_i[k];
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import booth_mac_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  mac_op_e          op_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_o,
  output logic             ovf_o
);
  localparam int MSB = ACC_W - 1;

  logic [ACC_W-1:0] acc_q, acc_d, addend, sum;
  logic             ovf_q, ovf_d;

  assign addend = (op_i == OP_MAS) ? (~prod_i + 1'b1) : prod_i;
  assign sum    = acc_q + addend;

  always_comb begin
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (valid_i) begin
      unique case (op_i)
        OP_MPY, OP_SQR: begin
          acc_d = prod_i;
          ovf_d = 1'b0;
        end
        OP_MAC, OP_MAS, OP_SQRA: begin
          acc_d = sum;
          ovf_d = (acc_q[MSB] == addend[MSB]) && (sum[MSB] != acc_q[MSB]);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_o = acc_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/booth_mac.sv
module booth_mac
  import booth_mac_pkg::*;
#(
  parameter int OP_W     = 17,
  parameter int ACC_W    = 40,
  parameter int FIELD_LO = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             acc_sel_i,
  input  logic [ACC_W-1:0] ext_acc_i,
  output logic [ACC_W-1:0] result_o,
  output logic             ovf_o
);
  localparam int NPP      = (OP_W + 1) / 2;
  localparam int FIELD_HI = FIELD_LO + OP_W - 1;

  mac_op_e                   op;
  logic [OP_W-1:0]           opa, opb;
  logic [NPP-1:0][ACC_W-1:0] pp;
  logic [ACC_W-1:0]          prod;
  logic                      unused_ext;

  assign op         = mac_op_e'(op_i);
  assign opa        = acc_sel_i ? ext_acc_i[FIELD_HI:FIELD_LO] : a_i;
  assign opb        = (op == OP_SQR || op == OP_SQRA) ? opa : b_i;
  assign unused_ext = ^{ext_acc_i[ACC_W-1:FIELD_HI+1], ext_acc_i[FIELD_LO-1:0]};

  booth_pp_gen #(.OP_W(OP_W), .ACC_W(ACC_W)) u_pp_gen (
    .mcand_i (opa),
    .mplier_i(opb),
    .pp_o    (pp)
  );

  booth_pp_sum #(.NPP(NPP), .ACC_W(ACC_W)) u_pp_sum (
    .pp_i  (pp),
    .prod_o(prod)
  );

  mac_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .op_i   (op),
    .prod_i (prod),
    .acc_o  (result_o),
    .ovf_o  (ovf_o)
  );
endmodule

// File: rtl/booth_mac_chk.sv
module booth_mac_chk #(
  parameter int OP_W     = 17,
  parameter int ACC_W    = 40,
  parameter int FIELD_LO = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [2:0]       op_i,
  input logic [OP_W-1:0]  a_i,
  input logic [OP_W-1:0]  b_i,
  input logic             acc_sel_i,
  input logic [ACC_W-1:0] ext_acc_i,
  input logic [ACC_W-1:0] result_o,
  input logic             ovf_o
);
  logic signed [OP_W-1:0]  sa, sb;
  logic signed [ACC_W-1:0] ref_prod;

  assign sa       = acc_sel_i ? ext_acc_i[FIELD_LO+OP_W-1:FIELD_LO] : a_i;
  assign sb       = (op_i == 3'd3 || op_i == 3'd4) ? sa : b_i;
  assign ref_prod = sa * sb;

  AST_RESET_ZERO: assert property (@(posedge clk_i) $rose(rst_ni) |-> result_o == '0 && !ovf_o); // R1
  AST_LOAD_PROD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd0 |=> result_o == $past(ref_prod)); // R2
  AST_ACCUM_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd1 |=> result_o == $past(result_o) + $past(ref_prod)); // R3
  AST_ACCUM_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 3'd2 |=> result_o == $past(result_o) - $past(ref_prod)); // R4
  AST_LOAD_CLEARS_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 3'd0 || op_i == 3'd3) |=> !ovf_o); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i || op_i > 3'd4 |=> $stable(result_o) && $stable(ovf_o)); // R8
endmodule

bind booth_mac booth_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .FIELD_LO(FIELD_LO)) u_chk (.*);

// File: tb/tb_booth_mac.sv
`timescale 1ns/1ps
module tb_booth_mac;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [16:0] a_i = '0, b_i = '0;
  logic        acc_sel_i = 1'b0;
  logic [39:0] ext_acc_i = '0;
  logic [39:0] result_o;
  logic        ovf_o;

  int total = 0, bad = 0;
  logic [39:0] m_acc = '0;
  logic        m_ovf = 1'b0;

  always #4 clk_i = ~clk_i;

  booth_mac dut (.*);

  function automatic logic [39:0] mul40(logic [16:0] x, logic [16:0] y);
    logic signed [39:0] p;
    p = $signed(x) * $signed(y);
    return p;
  endfunction

  task automatic chk(string tag, logic [39:0] exp_r, logic exp_o);
    total++;
    if (result_o !== exp_r || ovf_o !== exp_o) begin
      bad++;
      $display("FAIL %s result=%h ovf=%b expected result=%h ovf=%b", tag, result_o, ovf_o, exp_r, exp_o);
    end
  endtask

  // drive at negedge, model, check at following negedge
  task automatic step(string tag, logic v, logic [2:0] op, logic [16:0] a, logic [16:0] b,
                      logic sel, logic [39:0] ext);
    logic [16:0] ea, eb;
    logic [39:0] p, s;
    valid_i = v; op_i = op; a_i = a; b_i = b; acc_sel_i = sel; ext_acc_i = ext;
    ea = sel ? ext[31:15] : a;
    eb = (op == 3'd3 || op == 3'd4) ? ea : b;
    p  = mul40(ea, eb);
    if (v) begin
      case (op)
        3'd0, 3'd3: begin m_acc = p; m_ovf = 1'b0; end
        3'd1, 3'd4: begin
          s = m_acc + p;
          m_ovf = (m_acc[39] == p[39]) && (s[39] != m_acc[39]);
          m_acc = s;
        end
        3'd2: begin
          s = m_acc - p;
          m_ovf = (m_acc[39] != p[39]) && (s[39] != m_acc[39]);
          m_acc = s;
        end
        default: ;
      endcase
    end
    @(negedge clk_i);
    chk(tag, m_acc, m_ovf);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk("R1 reset", '0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", '0, 1'b0);

    step("R2 mpy", 1, 3'd0, 17'd300, 17'h1FFF9, 0, '0);
    step("R2 mpy max", 1, 3'd0, 17'h0FFFF, 17'h0FFFF, 0, '0);
    step("R10 min*min", 1, 3'd0, 17'h10000, 17'h10000, 0, '0);
    step("R2 mpy min*1", 1, 3'd0, 17'h10000, 17'd1, 0, '0);
    step("R3 mac", 1, 3'd1, 17'h1FFFF, 17'd5, 0, '0);
    step("R4 mas", 1, 3'd2, 17'd77, 17'h10000, 0, '0);
    step("R5 sqr ignores b", 1, 3'd3, 17'h1F00F, 17'h0ABCD, 0, '0);
    step("R5 sqra", 1, 3'd4, 17'd1234, 17'h12345, 0, '0);
    step("R6 field operand", 1, 3'd0, 17'h0AAAA, 17'd3, 1, 40'hFF_8000_7FFF);
    step("R6 field square", 1, 3'd4, 17'd9, 17'd9, 1, 40'h12_3456_789A);
    step("R8 idle", 0, 3'd0, 17'd5, 17'd5, 0, '0);
    step("R8 reserved 5", 1, 3'd5, 17'd5, 17'd5, 0, '0);
    step("R8 reserved 7", 1, 3'd7, 17'h10000, 17'h10000, 0, '0);

    // drive to positive wrap: 128 x 2^32
    step("R10 start", 1, 3'd3, 17'h10000, 17'd0, 0, '0);
    for (int i = 1; i < 128; i++) step("R10 build", 1, 3'd4, 17'h10000, 17'd0, 0, '0);
    chk("R10 wrap value", 40'h80_0000_0000, 1'b1);
    step("R8 idle keeps ovf", 0, 3'd1, 17'd1, 17'd1, 0, '0);
    step("R7 neg wrap", 1, 3'd2, 17'h10000, 17'h10000, 0, '0);
    step("R7 clear on plain mac", 1, 3'd1, 17'd1, 17'd1, 0, '0);
    step("R7 load clears", 1, 3'd0, 17'd2, 17'd3, 0, '0);

    // R9 back-to-back random mix
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step("R9 random", ($urandom_range(0, 7) != 0), op, 17'($urandom), 17'($urandom),
           ($urandom_range(0, 3) == 0), {$urandom, $urandom} >> 24);
    end
    for (int i = 0; i < 400; i++)
      step("R3 random mac", 1, 3'($urandom_range(1, 2)), 17'($urandom), 17'($urandom), 0, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule